// File: doc/BRIEF.md
# Touch Controller Serial Slave Interface

This block is the two-wire serial slave front end of a resistive touch-screen controller. It oversamples the bus clock and data lines on the system clock, finds START, repeated START and STOP conditions, and decodes a 7-bit device address. The address is a fixed six-bit prefix followed by one bit taken from a strap pin. A write transfer carries a single control byte. The block stores that byte and presents its channel, power-down, resolution and wake fields to the converter and panel-driver logic.

A read transfer returns the latest conversion result, most significant part first. In 12-bit mode the result takes two bytes, and the low nibble of the second byte is zero. In 8-bit mode the result is one byte. The block watches the master's acknowledge after each byte. Every read raises a conversion strobe. A count of bus clock rising edges since the last START lets the converter and the drivers line up their sample and settle windows with the bus.

Top module: `tsc_i2c_slave`

## Requirements
- R1: An address byte of 1,0,0,1,0,0, then the value of strap_i, then R/W (1 = read, 0 = write), sent MSB first, is acknowledged: the slave holds SDA low through the ninth clock high phase.
- R2: An address byte that does not match is not acknowledged. The slave keeps SDA released and ignores all bus clocks until the next START, so the command fields do not change.
- R3: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are detected at any point. A repeated START abandons a partly received command byte and begins a new address phase.
- R4: After a matched write address, the next byte (MSB first) is acknowledged and stored. cmd_stb_o pulses for exactly one system clock, at the 17th SCL rising edge after START.
- R5: Command byte decode: bit 7 drives wake_o, bits 6..4 drive chan_o, bit 2 drives pd_o, and bit 1 drives res8_o (1 = 8-bit, 0 = 12-bit). Bits 3 and 0 are ignored. The fields change only with cmd_stb_o.
- R6: In 12-bit mode a read returns result bits 11..4 first. If the master acknowledges, a second byte follows: bits 3..0, then four zeros.
- R7: In 8-bit mode a read returns only result bits 11..4. SDA stays released for any further clocks, even if the master acknowledges.
- R8: After the master does not acknowledge a byte, the slave sends nothing more and keeps SDA released until STOP or START.
- R9: Each matched read address pulses conv_start_o once, at the 8th SCL rising edge. The result is taken from adc_data_i when the address acknowledge ends. Back-to-back reads reuse the last stored command without a new write.
- R10: scl_cnt_o counts SCL rising edges since the last START and saturates at its maximum (31). scl_rise_o pulses once for each rising edge.
- R11: The slave changes SDA only while the synchronized SCL is low.
- R12: After reset, SDA is released, all command fields are zero and scl_cnt_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 1 | Pin-strapped low address bit |
| adc_data_i | input | ADC_W (12) | Conversion result from the converter |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wake_o | output | 1 | Command bit 7: wake/axis command, 0 means sleep |
| chan_o | output | 3 | Command channel select |
| pd_o | output | 1 | Command power-down select |
| res8_o | output | 1 | Command resolution, 1 = 8-bit |
| cmd_stb_o | output | 1 | One-cycle pulse when a new command is stored |
| conv_start_o | output | 1 | One-cycle pulse that starts a conversion |
| scl_rise_o | output | 1 | One-cycle pulse for each SCL rising edge |
| scl_cnt_o | output | CNT_W (5) | SCL rising edges since the last START, saturating |

## Verification
Two events can fall in the same system cycle. The first is the store of a command, where cmd_stb_o and the new fields change on the same edge that moves scl_cnt_o to 17. The second is a read address match, where conv_start_o fires on the edge that moves scl_cnt_o to 8. The bench sends write and read transfers with varied command bytes and results. It checks the counter value and the strobe counts against the number of clocks it has sent itself. A repeated START partway through a command byte, and extra clocks after a NACK, test whether an abandoned transfer can still update the command or disturb SDA.

// File: rtl/tsc_i2c_pkg.sv
package tsc_i2c_pkg;
  localparam logic [5:0] ADDR_PREFIX = 6'b100100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } st_e;

  typedef struct packed {
    logic       wake;
    logic [2:0] chan;
    logic       pd;
    logic       res8;
  } cmd_t;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[0] <= '1;
        else         pipe[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '1;
        else         pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tsc_bus_cond.sv
module tsc_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edges only count while the clock stays high across both samples
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/tsc_scl_cnt.sv
module tsc_scl_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tsc_i2c_fsm.sv
module tsc_i2c_fsm
  import tsc_i2c_pkg::*;
#(
  parameter int ADC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             sda_oe_o,
  output cmd_t             cmd_o,
  output logic             cmd_stb_o,
  output logic             conv_start_o
);
  localparam int LO_W = ADC_W - 8;

  st_e             st;
  logic [2:0]      bit_cnt;
  logic [7:0]      sh;
  logic            ack_half;
  logic            ack_drv;
  logic            is_read;
  logic            second;
  logic [LO_W-1:0] lo_q;
  logic [LO_W+7:0] lo_ext;
  logic [7:0]      lo_byte;
  logic [7:0]      hi_byte;

  assign hi_byte = adc_data_i[ADC_W-1 -: 8];
  assign lo_ext  = {lo_q, 8'h00};
  assign lo_byte = lo_ext[LO_W+7 -: 8];

  assign sda_oe_o = ack_drv | ((st == ST_TX) & ~sh[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st           <= ST_IDLE;
      bit_cnt      <= '0;
      sh           <= '0;
      ack_half     <= 1'b0;
      ack_drv      <= 1'b0;
      is_read      <= 1'b0;
      second       <= 1'b0;
      lo_q         <= '0;
      cmd_o        <= '0;
      cmd_stb_o    <= 1'b0;
      conv_start_o <= 1'b0;
    end else begin
      cmd_stb_o    <= 1'b0;
      conv_start_o <= 1'b0;
      if (start_i) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        ack_half <= 1'b0;
        ack_drv  <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        ack_half <= 1'b0;
        ack_drv  <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: if (scl_rise_i) begin
            sh      <= {sh[6:0], sda_s_i};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (sh[6:1] == ADDR_PREFIX && sh[0] == strap_i) begin
                st           <= ST_ADDR_ACK;
                is_read      <= sda_s_i;
                conv_start_o <= sda_s_i;
                ack_half     <= 1'b0;
              end else begin
                st <= ST_HOLD;
              end
            end
          end

          ST_ADDR_ACK, ST_CMD_ACK: if (scl_fall_i) begin
            if (!ack_half) begin
              ack_drv  <= 1'b1;
              ack_half <= 1'b1;
            end else begin
              ack_drv  <= 1'b0;
              ack_half <= 1'b0;
              bit_cnt  <= '0;
              if (st == ST_CMD_ACK) begin
                st <= ST_HOLD;
              end else if (is_read) begin
                sh     <= hi_byte;
                lo_q   <= adc_data_i[LO_W-1:0];
                second <= 1'b0;
                st     <= ST_TX;
              end else begin
                st <= ST_CMD;
              end
            end
          end

          ST_CMD: if (scl_rise_i) begin
            sh      <= {sh[6:0], sda_s_i};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              // byte = {sh[6:0], sda}: bit7 wake, 6..4 chan, 2 pd, 1 res8
              cmd_o.wake <= sh[6];
              cmd_o.chan <= sh[5:3];
              cmd_o.pd   <= sh[1];
              cmd_o.res8 <= sh[0];
              cmd_stb_o  <= 1'b1;
              ack_half   <= 1'b0;
              st         <= ST_CMD_ACK;
            end
          end

          ST_TX: if (scl_fall_i) begin
            if (bit_cnt == 3'd7) begin
              bit_cnt  <= '0;
              ack_half <= 1'b0;
              st       <= ST_MACK;
            end else begin
              sh      <= {sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end

          ST_MACK: begin
            if (scl_rise_i) begin
              if (!sda_s_i && !second && !cmd_o.res8) ack_half <= 1'b1;
              else                                    st       <= ST_HOLD;
            end else if (scl_fall_i && ack_half) begin
              ack_half <= 1'b0;
              second   <= 1'b1;
              sh       <= lo_byte;
              bit_cnt  <= '0;
              st       <= ST_TX;
            end
          end

          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsc_i2c_slave.sv
module tsc_i2c_slave
  import tsc_i2c_pkg::*;
#(
  parameter int ADC_W       = 12,
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             strap_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             sda_oe_o,
  output logic             wake_o,
  output logic [2:0]       chan_o,
  output logic             pd_o,
  output logic             res8_o,
  output logic             cmd_stb_o,
  output logic             conv_start_o,
  output logic             scl_rise_o,
  output logic [CNT_W-1:0] scl_cnt_o
);
  logic scl_s, sda_s;
  logic scl_fall, bus_start, bus_stop;
  cmd_t cmd;

  tsc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  tsc_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise_o),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  tsc_scl_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bus_start),
    .inc_i  (scl_rise_o),
    .cnt_o  (scl_cnt_o)
  );

  tsc_i2c_fsm #(.ADC_W(ADC_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_i      (strap_i),
    .sda_s_i      (sda_s),
    .scl_rise_i   (scl_rise_o),
    .scl_fall_i   (scl_fall),
    .start_i      (bus_start),
    .stop_i       (bus_stop),
    .adc_data_i   (adc_data_i),
    .sda_oe_o     (sda_oe_o),
    .cmd_o        (cmd),
    .cmd_stb_o    (cmd_stb_o),
    .conv_start_o (conv_start_o)
  );

  assign wake_o = cmd.wake;
  assign chan_o = cmd.chan;
  assign pd_o   = cmd.pd;
  assign res8_o = cmd.res8;
endmodule

// File: rtl/tsc_i2c_slave_chk.sv
module tsc_i2c_slave_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             bus_start,
  input logic             sda_oe_o,
  input logic             cmd_stb_o,
  input logic             conv_start_o,
  input logic [CNT_W-1:0] scl_cnt_o,
  input logic [5:0]       fields
);
  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s)); // R11

  AST_CMD_AT_17: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> scl_cnt_o == CNT_W'(17)); // R4

  AST_CMD_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o); // R4

  AST_FIELDS_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fields != $past(fields)) |-> cmd_stb_o); // R5

  AST_CONV_AT_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> scl_cnt_o == CNT_W'(8)); // R9

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start |=> scl_cnt_o == '0); // R10
endmodule

bind tsc_i2c_slave tsc_i2c_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s        (scl_s),
  .bus_start    (bus_start),
  .sda_oe_o     (sda_oe_o),
  .cmd_stb_o    (cmd_stb_o),
  .conv_start_o (conv_start_o),
  .scl_cnt_o    (scl_cnt_o),
  .fields       ({wake_o, chan_o, pd_o, res8_o})
);

// File: tb/sim_tsc_i2c_slave.sv
module sim_tsc_i2c_slave;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [11:0] adc;
    logic [7:0]  hi;
    logic [7:0]  lo;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'h90, 12'hABC, 8'hAB, 8'hC0},
    '{8'hD0, 12'h123, 8'h12, 8'h30},
    '{8'h92, 12'hFED, 8'hFE, 8'hFF},
    '{8'hA4, 12'h00F, 8'h00, 8'hF0},
    '{8'hFB, 12'h5A5, 8'h5A, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        strap = 1'b0;
  logic [11:0] adc = '0;
  logic        sda_oe, wake, pd, res8, cmd_stb, conv_start, scl_rise;
  logic [2:0]  chan;
  logic [4:0]  scl_cnt;
  wire         sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  int conv_cnt = 0;
  int viol = 0;
  int oe_seen = 0;
  logic oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .adc_data_i(adc), .sda_oe_o(sda_oe),
    .wake_o(wake), .chan_o(chan), .pd_o(pd), .res8_o(res8),
    .cmd_stb_o(cmd_stb), .conv_start_o(conv_start),
    .scl_rise_o(scl_rise), .scl_cnt_o(scl_cnt)
  );

  always @(negedge clk) begin
    if (cmd_stb) stb_cnt++;
    if (conv_start) conv_cnt++;
    if (sda_oe) oe_seen++;
    if (sda_oe != oe_prev && m_scl) viol++;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    cw(5); m_sda = 1'b1; cw(10); m_scl = 1'b1; cw(10); m_sda = 1'b0; cw(10); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    cw(5); m_sda = 1'b0; cw(10); m_scl = 1'b1; cw(10); m_sda = 1'b1; cw(20);
  endtask

  task automatic put_bit(input logic b);
    cw(5); m_sda = b; cw(15); m_scl = 1'b1; cw(20); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic v);
    cw(5); m_sda = 1'b1; cw(15); m_scl = 1'b1; cw(10); v = sda_line; cw(10); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    ack = ~v;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic m_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      b[i] = v;
    end
    put_bit(~m_ack);
  endtask

  function automatic logic [7:0] addr(input logic s, input logic rw);
    return {6'b100100, s, rw};
  endfunction

  task automatic write_cmd(input logic [7:0] c, output logic a1, output logic a2);
    bus_start();
    send_byte(addr(strap, 1'b0), a1);
    send_byte(c, a2);
    bus_stop();
  endtask

  task automatic check_fields(input logic [7:0] c, input string req);
    check({wake, chan, pd, res8} == {c[7], c[6:4], c[2], c[1]}, req,
          {wake, chan, pd, res8}, {c[7], c[6:4], c[2], c[1]});
  endtask

  initial begin
    cw(150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic       a1, a2;
    logic [7:0] b1, b2;
    int         s0, c0;

    cw(5);
    // R12 reset state
    check(sda_oe == 1'b0, "R12 sda", sda_oe, 0);
    check({wake, chan, pd, res8} == 6'd0, "R12 fields", {wake, chan, pd, res8}, 0);
    check(scl_cnt == 5'd0, "R12 count", scl_cnt, 0);
    rst_n = 1'b1;
    cw(10);

    // table: write a command, then read back the result
    for (int k = 0; k < NV; k++) begin
      s0 = stb_cnt;
      write_cmd(VECS[k].cmd, a1, a2);
      check(a1, "R1 write addr ack", a1, 1);
      check(a2, "R4 cmd ack", a2, 1);
      check(stb_cnt == s0 + 1, "R4 strobe", stb_cnt - s0, 1);
      check_fields(VECS[k].cmd, "R5 decode");
      adc = VECS[k].adc;
      c0 = conv_cnt;
      bus_start();
      send_byte(addr(strap, 1'b1), a1);
      check(a1, "R1 read addr ack", a1, 1);
      recv_byte(b1, 1'b1);
      recv_byte(b2, 1'b0);
      bus_stop();
      check(b1 == VECS[k].hi, "R6 high byte", b1, VECS[k].hi);
      check(b2 == VECS[k].lo, VECS[k].cmd[1] ? "R7 no second byte" : "R6 low byte",
            b2, VECS[k].lo);
      check(conv_cnt == c0 + 1, "R9 conv per read", conv_cnt - c0, 1);
    end

    // R10 count after address + ack, R4 via strobe
    bus_start();
    send_byte(addr(strap, 1'b0), a1);
    cw(2);
    check(scl_cnt == 5'd9, "R10 count after address", scl_cnt, 9);
    send_byte(8'h90, a2);
    bus_stop();
    check_fields(8'h90, "R5 set 12-bit");

    // R2 address mismatch: no ack, SDA untouched, command kept
    oe_seen = 0;
    bus_start();
    send_byte(addr(~strap, 1'b0), a1);
    send_byte(8'hFF, a2);
    bus_stop();
    check(!a1, "R2 no addr ack", a1, 0);
    check(!a2, "R2 no data ack", a2, 0);
    check(oe_seen == 0, "R2 sda released", oe_seen, 0);
    check_fields(8'h90, "R2 command kept");

    // R8 master NACK on first byte; R10 saturation
    adc = 12'h4D2;
    bus_start();
    send_byte(addr(strap, 1'b1), a1);
    recv_byte(b1, 1'b0);
    recv_byte(b2, 1'b0);
    recv_byte(b2, 1'b0);
    cw(2);
    check(b1 == 8'h4D, "R8 first byte", b1, 8'h4D);
    check(b2 == 8'hFF, "R8 released after nack", b2, 8'hFF);
    check(scl_cnt == 5'd31, "R10 saturate", scl_cnt, 31);
    bus_stop();

    // R9 back-to-back reads with repeated START, no write
    c0 = conv_cnt;
    adc = 12'h7E1;
    bus_start();
    send_byte(addr(strap, 1'b1), a1);
    recv_byte(b1, 1'b1);
    recv_byte(b2, 1'b0);
    check({b1, b2} == 16'h7E10, "R9 first read", {b1, b2}, 16'h7E10);
    adc = 12'h3C4;
    bus_start();
    send_byte(addr(strap, 1'b1), a1);
    recv_byte(b1, 1'b1);
    recv_byte(b2, 1'b0);
    bus_stop();
    check({b1, b2} == 16'h3C40, "R9 second read", {b1, b2}, 16'h3C40);
    check(conv_cnt == c0 + 2, "R9 two conversions", conv_cnt - c0, 2);

    // R3 repeated START inside a command byte
    s0 = stb_cnt;
    bus_start();
    send_byte(addr(strap, 1'b0), a1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    adc = 12'h865;
    bus_start();
    send_byte(addr(strap, 1'b1), a1);
    check(a1, "R3 new address after restart", a1, 1);
    recv_byte(b1, 1'b1);
    recv_byte(b2, 1'b0);
    bus_stop();
    check({b1, b2} == 16'h8650, "R3 read after restart", {b1, b2}, 16'h8650);
    check(stb_cnt == s0, "R3 no store", stb_cnt - s0, 0);
    check_fields(8'h90, "R3 command kept");

    // R1 strap high
    strap = 1'b1;
    cw(5);
    write_cmd(8'hC0, a1, a2);
    check(a1 && a2, "R1 strap high ack", {a1, a2}, 3);
    check_fields(8'hC0, "R5 strap high cmd");

    check(viol == 0, "R11 sda only with scl low", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule